// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Set/Clear Control Registers

This block sits between a host processor and six peripheral units. Each unit reports an event with a one-cycle pulse, and the block holds that event as a pending flag until it is acknowledged. Every flag is gated by its own enable bit, and the gated flags are ORed into a single request line to the host. The block also holds a small control word with three on/off flags and a 7-bit length field, and a read-only revision word that is fixed by a parameter.

The host reaches four 32-bit registers over a single-cycle bus. The bus carries a byte address, a write strobe and write data, and returns read data combinationally. Only address bits above bit 1 select a register. Enable bits and control flags are never written as values. Each one has its own set command bit and its own clear command bit, so a write changes only the flags it names. Because of this, the write layout of the control and enable registers differs from their read layout. One command bit in the control register also acknowledges the pending flag of source 5, which has no acknowledge pin of its own.

Top module: `irq_hub`

## Requirements
- R1: After reset, every control flag, the length field, every enable bit and every pending flag is 0, and `cpu_irq` is low.
- R2: A write to offset 0x00 updates three control flags. Bit 13 sets the register-access flag and bit 12 clears it. Bit 10 sets the test flag and bit 9 clears it. Bit 8 sets the init flag and bit 7 clears it. If a write asserts both the set bit and the clear bit of one flag, that flag keeps its value. A read of 0x00 returns the register-access flag on bit 9, the test flag on bit 8 and the init flag on bit 7.
- R3: Every write to offset 0x00 loads bits 6:0 into the length field. A read of 0x00 returns that field on bits 6:0, and bits 31:10 read 0.
- R4: A write to offset 0x0C changes enable bit k (k = 0..5) through a pair of bits: bit 2k clears it and bit 2k+1 sets it. If both bits are set, enable bit k keeps its value. A read of 0x0C returns the six enable bits on bits 5:0 and 0 elsewhere.
- R5: A pulse on `src_raise[k]` sets pending flag k on the next clock edge. A read of 0x08 returns the pending flags on bits 5:0 and 0 elsewhere. Writes to 0x08 have no effect.
- R6: For sources 0..4, `src_clear[k]` clears pending flag k. If `src_raise[k]` is high in the same cycle, the raise wins.
- R7: A write to offset 0x00 with bit 11 set clears pending flag 5. If `src_raise[5]` is high in the same cycle, the raise wins.
- R8: `cpu_irq` is high exactly when some pending flag and its enable bit are both 1. It follows the registered flags with no added delay.
- R9: A read of 0x04 returns the `VERSION` parameter. Writes to 0x04 change no state.
- R10: Address bits 1:0 are ignored. Offsets 0x10 to 0x1F read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data / command bits |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| src_raise | input | NUM_SRC (6) | One-cycle event pulses, one per source |
| src_clear | input | NUM_SRC-1 (5) | Acknowledge pins for sources 0..4 |
| cpu_irq | output | 1 | Combined masked interrupt request |

## Verification
Two functions can act on one pending flag in the same cycle: a new event pulse and an acknowledge. The acknowledge is either a pin clear for sources 0..4 or a control-register write with bit 11 set for source 5. The bench forces both in one cycle. It sweeps every combination of raise and clear pins, and during the full sweep of control-register write values it pulses source 5 on every third write. After each cycle it reads the pending register back and expects the raise to win. The same sweeps also exercise set and clear commands that hit the same flag in one write, and the bench expects that flag to keep its previous value.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   // Register slots selected by address bits [3:2]
   typedef enum logic [1:0] {
      SLOT_CTRL = 2'd0,
      SLOT_REV  = 2'd1,
      SLOT_PEND = 2'd2,
      SLOT_EN   = 2'd3
   } slot_e;

   // Paired set/clear update: a lone set or a lone clear acts, both together hold
   function automatic logic sc_next(input logic cur, input logic set_b, input logic clr_b);
      logic nxt;
      if (set_b && !clr_b)
         nxt = 1'b1;
      else if (clr_b && !set_b)
         nxt = 1'b0;
      else
         nxt = cur;
      return nxt;
   endfunction

endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
   import irq_hub_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_word,
   output logic              ack_pulse
);

   // Write command positions, stacked directly above the length field
   localparam int W_INIT_CLR = LEN_W;
   localparam int W_INIT_SET = LEN_W + 1;
   localparam int W_TEST_CLR = LEN_W + 2;
   localparam int W_TEST_SET = LEN_W + 3;
   localparam int W_ACK      = LEN_W + 4;
   localparam int W_ACC_CLR  = LEN_W + 5;
   localparam int W_ACC_SET  = LEN_W + 6;
   localparam int USED_W     = LEN_W + 7;

   // Read layout: {acc, test, init, len} packed from bit 0 upward
   typedef struct packed {
      logic             acc;
      logic             test;
      logic             init;
      logic [LEN_W-1:0] len;
   } ctrl_t;

   ctrl_t ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q.acc  <= sc_next(ctrl_q.acc,  wdata[W_ACC_SET],  wdata[W_ACC_CLR]);
         ctrl_q.test <= sc_next(ctrl_q.test, wdata[W_TEST_SET], wdata[W_TEST_CLR]);
         ctrl_q.init <= sc_next(ctrl_q.init, wdata[W_INIT_SET], wdata[W_INIT_CLR]);
         ctrl_q.len  <= wdata[LEN_W-1:0];
      end
   end

   assign ctrl_word = DATA_W'(ctrl_q);
   assign ack_pulse = wr_en & wdata[W_ACK];

   generate
      if (DATA_W > USED_W) begin : g_spare
         logic spare_unused;
         assign spare_unused = ^wdata[DATA_W-1:USED_W];
      end
   endgenerate

endmodule

// File: rtl/irq_hub_flags.sv
module irq_hub_flags
   import irq_hub_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_SRC = 6,
   parameter int ACK_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_wr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] raise,
   input  logic [NUM_SRC-2:0] pin_clr,
   input  logic               ack,
   output logic [NUM_SRC-1:0] pend_q,
   output logic [NUM_SRC-1:0] en_q,
   output logic               irq
);

   localparam int CMD_W = 2 * NUM_SRC;

   logic [NUM_SRC-1:0] pend_d;
   logic [NUM_SRC-1:0] en_d;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      logic drop;
      // The source picked by ACK_SRC is acknowledged by a control write,
      // the others by their own pins, packed without a gap
      if (k == ACK_SRC) begin : g_by_write
         assign drop = ack;
      end else if (k < ACK_SRC) begin : g_pin_lo
         assign drop = pin_clr[k];
      end else begin : g_pin_hi
         assign drop = pin_clr[k-1];
      end

      assign pend_d[k] = raise[k] ? 1'b1 : (drop ? 1'b0 : pend_q[k]);
      assign en_d[k]   = en_wr ? sc_next(en_q[k], wdata[2*k+1], wdata[2*k]) : en_q[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
      end else begin
         pend_q <= pend_d;
         en_q   <= en_d;
      end
   end

   assign irq = |(pend_q & en_q);

   generate
      if (DATA_W > CMD_W) begin : g_spare
         logic spare_unused;
         assign spare_unused = ^wdata[DATA_W-1:CMD_W];
      end
   endgenerate

endmodule

// File: rtl/irq_hub_rdmux.sv
module irq_hub_rdmux
   import irq_hub_pkg::*;
#(
   parameter int              DATA_W  = 32,
   parameter int              SLOT_W  = 3,
   parameter int              NUM_SRC = 6,
   parameter logic [DATA_W-1:0] VERSION = '0
) (
   input  logic [SLOT_W-1:0]  slot,
   input  logic [DATA_W-1:0]  ctrl_word,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] en,
   output logic [DATA_W-1:0]  rdata
);

   logic mapped;

   generate
      if (SLOT_W > 2) begin : g_wide
         assign mapped = (slot[SLOT_W-1:2] == '0);
      end else begin : g_exact
         assign mapped = 1'b1;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (mapped) begin
         unique case (slot_e'(slot[1:0]))
            SLOT_CTRL: rdata = ctrl_word;
            SLOT_REV:  rdata = VERSION;
            SLOT_PEND: rdata = DATA_W'(pend);
            SLOT_EN:   rdata = DATA_W'(en);
            default:   rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int                DATA_W  = 32,
   parameter int                ADDR_W  = 5,
   parameter int                NUM_SRC = 6,
   parameter int                LEN_W   = 7,
   parameter int                ACK_SRC = 5,
   parameter logic [DATA_W-1:0] VERSION = 32'h0202_0102
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_raise,
   input  logic [NUM_SRC-2:0] src_clear,
   output logic               cpu_irq
);

   localparam int SLOT_W = ADDR_W - 2;

   generate
      if (ADDR_W < 4) begin : g_chk_addr
         $error("irq_hub: ADDR_W must cover four word slots");
      end
      if (NUM_SRC < 2 || 2 * NUM_SRC > DATA_W) begin : g_chk_src
         $error("irq_hub: NUM_SRC set/clear pairs do not fit the data word");
      end
      if (LEN_W + 7 > DATA_W) begin : g_chk_len
         $error("irq_hub: control command bits do not fit the data word");
      end
      if (ACK_SRC < 0 || ACK_SRC >= NUM_SRC) begin : g_chk_ack
         $error("irq_hub: ACK_SRC out of range");
      end
   endgenerate

   logic [SLOT_W-1:0]  slot;
   logic               ctrl_wr;
   logic               en_wr;
   logic               ack_pulse;
   logic [DATA_W-1:0]  ctrl_word;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               lane_unused;

   assign slot        = bus_addr[ADDR_W-1:2];
   assign lane_unused = ^bus_addr[1:0];
   assign ctrl_wr     = bus_we && (slot == SLOT_W'(SLOT_CTRL));
   assign en_wr       = bus_we && (slot == SLOT_W'(SLOT_EN));

   irq_hub_ctrl #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctrl_wr),
      .wdata     (bus_wdata),
      .ctrl_word (ctrl_word),
      .ack_pulse (ack_pulse)
   );

   irq_hub_flags #(
      .DATA_W  (DATA_W),
      .NUM_SRC (NUM_SRC),
      .ACK_SRC (ACK_SRC)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_wr   (en_wr),
      .wdata   (bus_wdata),
      .raise   (src_raise),
      .pin_clr (src_clear),
      .ack     (ack_pulse),
      .pend_q  (pend_q),
      .en_q    (mask_q),
      .irq     (cpu_irq)
   );

   irq_hub_rdmux #(
      .DATA_W  (DATA_W),
      .SLOT_W  (SLOT_W),
      .NUM_SRC (NUM_SRC),
      .VERSION (VERSION)
   ) u_rdmux (
      .slot      (slot),
      .ctrl_word (ctrl_word),
      .pend      (pend_q),
      .en        (mask_q),
      .rdata     (bus_rdata)
   );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
   parameter int                DATA_W  = 32,
   parameter int                ADDR_W  = 5,
   parameter int                NUM_SRC = 6,
   parameter int                LEN_W   = 7,
   parameter int                ACK_SRC = 5,
   parameter logic [DATA_W-1:0] VERSION = '0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_we,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_SRC-1:0] src_raise,
   input logic [NUM_SRC-2:0] src_clear,
   input logic               cpu_irq,
   input logic [NUM_SRC-1:0] pend_q,
   input logic [NUM_SRC-1:0] mask_q
);

   localparam int SLOT_W = ADDR_W - 2;
   localparam int ACK_BIT = LEN_W + 4;

   logic [SLOT_W-1:0] slot;
   logic ctrl_hit, en_hit, rev_sel, unmapped_sel;
   logic probe_unused;

   assign slot         = bus_addr[ADDR_W-1:2];
   assign ctrl_hit     = bus_we && (slot == SLOT_W'(0));
   assign en_hit       = bus_we && (slot == SLOT_W'(3));
   assign rev_sel      = (slot == SLOT_W'(1));
   assign unmapped_sel = (slot > SLOT_W'(3));
   assign probe_unused = ^{bus_addr[1:0], bus_wdata};

   // R9: the revision slot always returns the parameter
   a_r9_version_read: assert property (@(posedge clk) disable iff (!rst_n)
      rev_sel |-> (bus_rdata == VERSION));

   // R10: offsets above the map read zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped_sel |-> (bus_rdata == '0));

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      // R5: a raise pulse always leaves the flag set
      a_r5_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
         src_raise[k] |=> pend_q[k]);

      // R8: an enabled raise reaches the request line next cycle
      a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (src_raise[k] && mask_q[k] && !bus_we) |=> cpu_irq);

      // R4: set and clear together leave the enable bit alone
      a_r4_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (en_hit && bus_wdata[2*k] && bus_wdata[2*k+1]) |=> $stable(mask_q[k]));

      if (k == ACK_SRC) begin : g_ack
         // R7: a control write acknowledge drops the flag when no raise collides
         a_r7_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_hit && bus_wdata[ACK_BIT] && !src_raise[k]) |=> !pend_q[k]);
      end else begin : g_pin
         localparam int CI = (k < ACK_SRC) ? k : k - 1;
         // R6: a pin acknowledge drops the flag when no raise collides
         a_r6_pin_ack: assert property (@(posedge clk) disable iff (!rst_n)
            (src_clear[CI] && !src_raise[k]) |=> !pend_q[k]);
      end
   end

endmodule

bind irq_hub irq_hub_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .NUM_SRC (NUM_SRC),
   .LEN_W   (LEN_W),
   .ACK_SRC (ACK_SRC),
   .VERSION (VERSION)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .src_raise (src_raise),
   .src_clear (src_clear),
   .cpu_irq   (cpu_irq),
   .pend_q    (pend_q),
   .mask_q    (mask_q)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] VER_EXP    = 32'h0201_0202;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  src_raise = '0;
   logic [4:0]  src_clear = '0;
   logic        cpu_irq;

   int total = 0;
   int bad = 0;

   // Reference state
   logic       m_acc = 1'b0, m_test = 1'b0, m_init = 1'b0;
   logic [6:0] m_len = '0;
   logic [5:0] m_pend = '0, m_en = '0;

   irq_hub #(.VERSION(VER_EXP)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .src_raise (src_raise),
      .src_clear (src_clear),
      .cpu_irq   (cpu_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic pair(input logic cur, input logic s, input logic c);
      return (s && !c) ? 1'b1 : ((c && !s) ? 1'b0 : cur);
   endfunction

   function automatic logic [31:0] expect_rd(input logic [4:0] a);
      case (a[4:2])
         3'd0: return {22'd0, m_acc, m_test, m_init, m_len};
         3'd1: return VER_EXP;
         3'd2: return {26'd0, m_pend};
         3'd3: return {26'd0, m_en};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One clock of stimulus; the model is advanced with the same inputs
   task automatic step(input logic [5:0] r, input logic [4:0] c, input logic we,
                       input logic [4:0] a, input logic [31:0] d);
      logic ack;
      @(negedge clk);
      src_raise = r; src_clear = c; bus_we = we; bus_addr = a; bus_wdata = d;
      ack = 1'b0;
      if (we && a[4:2] == 3'd0) begin
         m_acc  = pair(m_acc,  d[13], d[12]);
         m_test = pair(m_test, d[10], d[9]);
         m_init = pair(m_init, d[8],  d[7]);
         m_len  = d[6:0];
         ack    = d[11];
      end
      if (we && a[4:2] == 3'd3)
         for (int k = 0; k < 6; k++) m_en[k] = pair(m_en[k], d[2*k+1], d[2*k]);
      for (int k = 0; k < 5; k++)
         if (r[k]) m_pend[k] = 1'b1; else if (c[k]) m_pend[k] = 1'b0;
      if (r[5]) m_pend[5] = 1'b1; else if (ack) m_pend[5] = 1'b0;
      @(negedge clk);
      src_raise = '0; src_clear = '0; bus_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [4:0] a);
      bus_addr = a;
      #1;
      check(req, bus_rdata, expect_rd(a));
   endtask

   task automatic irq_chk(input string req);
      check(req, {31'd0, cpu_irq}, {31'd0, |(m_pend & m_en)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every register and the request line
      rd("R1 ctrl reset", 5'h00);
      rd("R1 pending reset", 5'h08);
      rd("R1 enable reset", 5'h0C);
      irq_chk("R1 irq reset");

      // R4: every enable command word, including same-bit set+clear pairs
      for (int w = 0; w < 4096; w++) begin
         step('0, '0, 1'b1, 5'h0C, 32'(w));
         rd("R4 enable readback", 5'h0C);
      end

      // R5/R6/R8: every raise/pin-clear combination, enables changed periodically
      for (int cmb = 0; cmb < 2048; cmb++) begin
         if (cmb[6:0] == 7'd0)
            step('0, '0, 1'b1, 5'h0C, 32'((cmb * 37 + 1365) & 12'hFFF));
         step(cmb[5:0], cmb[10:6], 1'b0, 5'h08, '0);
         rd("R5/R6 pending after raise/clear", 5'h08);
         irq_chk("R8 irq vs pending and enable");
      end

      // R2/R3/R7: every control command word, source 5 raised on every third write
      for (int w = 0; w < 16384; w++) begin
         step((w % 3 == 0) ? 6'h20 : 6'h00, '0, 1'b1, 5'h00, 32'(w));
         rd("R2/R3 ctrl readback", 5'h00);
         rd("R7 pending after write ack", 5'h08);
      end

      // R7: directed acknowledge without collision
      step(6'h20, '0, 1'b0, 5'h00, '0);
      rd("R7 source 5 raised", 5'h08);
      step('0, '0, 1'b1, 5'h00, 32'h0000_0800);
      rd("R7 source 5 acknowledged", 5'h08);

      // R8: enable everything, raise everything, then mask off
      step('0, '0, 1'b1, 5'h0C, 32'h0000_0AAA);
      step(6'h3F, '0, 1'b0, 5'h00, '0);
      irq_chk("R8 irq all enabled");
      step('0, '0, 1'b1, 5'h0C, 32'h0000_0555);
      irq_chk("R8 irq all masked");
      step('0, '0, 1'b1, 5'h0C, 32'h0000_0800);
      irq_chk("R8 irq one enabled");

      // R9: revision value and write immunity
      step(6'h00, 5'h00, 1'b0, 5'h00, '0);
      step('0, '0, 1'b1, 5'h00, 32'h0000_2555);
      rd("R9 version", 5'h04);
      step('0, '0, 1'b1, 5'h04, 32'hFFFF_FFFF);
      rd("R9 version after write", 5'h04);
      rd("R9 ctrl untouched", 5'h00);
      rd("R9 enable untouched", 5'h0C);
      rd("R9 pending untouched", 5'h08);

      // R5: pending register ignores writes
      step('0, '0, 1'b1, 5'h08, 32'h0000_0000);
      rd("R5 pending after write", 5'h08);

      // R10: unmapped offsets and ignored byte lanes
      for (int a = 16; a < 32; a++) begin
         step('0, '0, 1'b1, 5'(a), 32'hFFFF_FFFF);
         rd("R10 unmapped reads zero", 5'(a));
      end
      rd("R10 ctrl untouched", 5'h00);
      rd("R10 enable untouched", 5'h0C);
      rd("R10 pending untouched", 5'h08);
      rd("R10 byte lane 3 ignored", 5'h0B);
      rd("R10 byte lane 1 ignored", 5'h05);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule